// File: doc/BRIEF.md
# Best-Effort Transaction Failure Controller

This block follows one hardware thread through a best-effort hardware transaction. A begin strobe opens the transaction and carries the instruction address together with a signed PC-relative displacement. Their sum is kept as the failure target. A commit strobe closes the transaction successfully. While the transaction is open, the block watches two sets of inputs:

- per-instruction class codes from the decoder;
- asynchronous event lines: conflict, precise exception, interrupt, read-set eviction, load and store translation misses, and store-buffer overflow.

Any one of these can fail the transaction. On a failure the block ends the transaction and pulses a redirect carrying the failure target as the new PC, with the target plus 4 as the next PC. It also pulses a checkpoint-restore request. It ORs a bit-coded failure cause into a sticky status register. Software reads that register through a one-cycle read-status port.

Two configuration inputs relax the rules. The first allows a save followed by a restore. The second turns an inner begin into a flat-nested, absorbed begin.

Top module: `txn_fail_ctrl`

## Requirements
- R1: After reset, txn_active and all output pulses are 0 and the status register reads 0.
- R2: A begin while idle sets txn_active one cycle later. It records the failure target as begin_pc + begin_off, clears the status register and forgets any earlier save.
- R3: A commit while active with no failure condition drops txn_active and pulses commit_done for one cycle, one cycle later. A commit while idle has no effect.
- R4: A failure drops txn_active one cycle later. In that cycle redirect_valid and restore_req pulse for one cycle, with redirect_pc equal to the failure target and redirect_npc equal to the target plus 4.
- R5: Status bits are: 0x002 conflict, 0x004 trap instruction (insn_kind 1), 0x010 precise exception, 0x020 interrupt, 0x040 store-buffer overflow, 0x080 read-set eviction or load translation miss, 0x100 store translation miss.
- R6: Causes arriving in the same cycle are all recorded. Status bits stay set until the next begin.
- R7: insn_kind codes 4 (barrier), 5 (compare-and-swap), 6 (atomic byte load-store), 7 (privileged register write), 8 (cache flush), 9 (trap return) and 10 (integer divide) fail an active transaction with cause 0x008.
- R8: A restore (insn_kind 3) after a save (insn_kind 2) in the same transaction fails it with 0x008. A lone save or a lone restore does not fail it. With cfg_pair_ok = 1 the pair is allowed.
- R9: A begin while active fails the transaction with 0x008. With cfg_flat_nest = 1 the inner begin is absorbed and the failure target is unchanged.
- R10: Failure inputs and instruction codes while idle have no effect on any output or on the status register.
- R11: A failure and a commit in the same cycle resolve as a failure, with no commit_done.
- R12: A stat_rd_req pulse returns stat_rd_valid and the status value one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pair_ok | input | 1 | Allow save followed by restore |
| cfg_flat_nest | input | 1 | Absorb a begin issued while active |
| begin_valid | input | 1 | Begin strobe |
| begin_pc | input | ADDR_W | Address of the begin instruction |
| begin_off | input | ADDR_W | PC-relative failure displacement |
| commit_valid | input | 1 | Commit strobe |
| insn_valid | input | 1 | Instruction class code is valid |
| insn_kind | input | KIND_W | Instruction class code |
| ev_conflict | input | 1 | Conflicting memory request |
| ev_exception | input | 1 | Precise exception |
| ev_interrupt | input | 1 | Asynchronous interrupt |
| ev_rd_evict | input | 1 | Read-set line evicted |
| ev_tlb_ld | input | 1 | Load translation miss |
| ev_tlb_st | input | 1 | Store translation miss |
| ev_st_ovf | input | 1 | Store buffer over capacity |
| stat_rd_req | input | 1 | Read-status request |
| txn_active | output | 1 | Transaction open |
| redirect_valid | output | 1 | Failure redirect pulse |
| redirect_pc | output | ADDR_W | New PC on failure |
| redirect_npc | output | ADDR_W | New next PC on failure |
| restore_req | output | 1 | Checkpoint restore request |
| commit_done | output | 1 | Successful commit pulse |
| stat_rd_valid | output | 1 | Read-status data valid |
| stat_rd_data | output | STAT_W | Status register value |

## Verification
The bench builds the block with its defaults: ADDR_W = 32, a 4-bit instruction class and a 9-bit status. A 4-bit class code leaves room for every listed class, including codes above the unsupported set. A 32-bit address makes the plus-4 next PC and the summed displacement visible across distinct targets.

Both configuration inputs are toggled at run time, so the strict and relaxed behaviour of the save/restore rule and of nested begins are each reached in the same build.

// File: rtl/txn_pkg.sv
package txn_pkg;
  localparam int STAT_W = 9;
  localparam int KIND_W = 4;
  localparam int NPC_STEP = 4;

  typedef enum logic [KIND_W-1:0] {
    K_PLAIN   = 4'd0,
    K_TRAP    = 4'd1,
    K_SAVE    = 4'd2,
    K_RESTORE = 4'd3,
    K_BARRIER = 4'd4,
    K_CAS     = 4'd5,
    K_BYTEXCH = 4'd6,
    K_PRIVWR  = 4'd7,
    K_FLUSH   = 4'd8,
    K_TRAPRET = 4'd9,
    K_DIVIDE  = 4'd10
  } insn_kind_e;

  // status bit positions
  localparam int C_CONFLICT = 1;
  localparam int C_TRAP     = 2;
  localparam int C_UNSUP    = 3;
  localparam int C_PRECISE  = 4;
  localparam int C_ASYNC    = 5;
  localparam int C_SIZE     = 6;
  localparam int C_LOAD     = 7;
  localparam int C_STORE    = 8;

  // one bit per class code: set when the class is not allowed inside a transaction
  localparam logic [2**KIND_W-1:0] UNSUP_SET = 16'h07F0;
endpackage

// File: rtl/txn_cause_decode.sv
module txn_cause_decode
  import txn_pkg::*;
#(
  parameter int KW = KIND_W,
  parameter int SW = STAT_W
) (
  input  logic          active,
  input  logic          cfg_pair_ok,
  input  logic          cfg_flat_nest,
  input  logic          begin_valid,
  input  logic          insn_valid,
  input  logic [KW-1:0] insn_kind,
  input  logic          saw_save,
  input  logic          ev_conflict,
  input  logic          ev_exception,
  input  logic          ev_interrupt,
  input  logic          ev_rd_evict,
  input  logic          ev_tlb_ld,
  input  logic          ev_tlb_st,
  input  logic          ev_st_ovf,
  output logic [SW-1:0] cause
);
  logic is_trap, is_unsup, is_pair, is_nest;

  always_comb begin
    is_trap  = insn_valid && (insn_kind == KW'(K_TRAP));
    is_unsup = insn_valid && UNSUP_SET[insn_kind];
    is_pair  = insn_valid && (insn_kind == KW'(K_RESTORE)) && saw_save && !cfg_pair_ok;
    is_nest  = begin_valid && !cfg_flat_nest;
  end

  always_comb begin
    cause = '0;
    if (active) begin
      cause[C_CONFLICT] = ev_conflict;
      cause[C_TRAP]     = is_trap;
      cause[C_UNSUP]    = is_unsup || is_pair || is_nest;
      cause[C_PRECISE]  = ev_exception;
      cause[C_ASYNC]    = ev_interrupt;
      cause[C_SIZE]     = ev_st_ovf;
      cause[C_LOAD]     = ev_rd_evict || ev_tlb_ld;
      cause[C_STORE]    = ev_tlb_st;
    end
  end
endmodule

// File: rtl/txn_seq.sv
module txn_seq
  import txn_pkg::*;
#(
  parameter int AW = 32,
  parameter int KW = KIND_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          begin_valid,
  input  logic [AW-1:0] begin_pc,
  input  logic [AW-1:0] begin_off,
  input  logic          commit_valid,
  input  logic          insn_valid,
  input  logic [KW-1:0] insn_kind,
  input  logic          fail,
  output logic          active_q,
  output logic          saw_save_q,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc,
  output logic [AW-1:0] redirect_npc,
  output logic          restore_req,
  output logic          commit_done
);
  localparam logic [AW-1:0] STEP = AW'(NPC_STEP);
  logic [AW-1:0] target_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q       <= 1'b0;
      saw_save_q     <= 1'b0;
      target_q       <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      redirect_npc   <= '0;
      restore_req    <= 1'b0;
      commit_done    <= 1'b0;
    end else begin
      redirect_valid <= 1'b0;
      restore_req    <= 1'b0;
      commit_done    <= 1'b0;
      if (active_q) begin
        if (fail) begin
          active_q       <= 1'b0;
          saw_save_q     <= 1'b0;
          redirect_valid <= 1'b1;
          restore_req    <= 1'b1;
          redirect_pc    <= target_q;
          redirect_npc   <= target_q + STEP;
        end else if (commit_valid) begin
          active_q    <= 1'b0;
          saw_save_q  <= 1'b0;
          commit_done <= 1'b1;
        end else if (insn_valid && insn_kind == KW'(K_SAVE)) begin
          saw_save_q <= 1'b1;
        end
      end else if (begin_valid) begin
        active_q   <= 1'b1;
        saw_save_q <= 1'b0;
        target_q   <= begin_pc + begin_off;
      end
    end
  end

  p_fail_ends_r4: assert property (@(posedge clk) disable iff (rst)
    (active_q && fail) |=> (!active_q && redirect_valid && restore_req &&
                            redirect_npc == redirect_pc + STEP));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !active_q |=> (!redirect_valid && !commit_done && !restore_req));
  p_commit_r3: assert property (@(posedge clk) disable iff (rst)
    (active_q && commit_valid && !fail) |=> (commit_done && !active_q));
  p_fail_over_commit_r11: assert property (@(posedge clk) disable iff (rst)
    (active_q && fail && commit_valid) |=> (!commit_done && redirect_valid));
endmodule

// File: rtl/txn_status_reg.sv
module txn_status_reg
  import txn_pkg::*;
#(
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [SW-1:0] cause,
  input  logic          rd_req,
  output logic          rd_valid,
  output logic [SW-1:0] rd_data
);
  logic [SW-1:0] stat_q;

  for (genvar b = 0; b < SW; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || start) stat_q[b] <= 1'b0;
      else if (cause[b]) stat_q[b] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= stat_q;
    end
  end

  p_clear_on_start_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (stat_q == '0));
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    !start |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  p_read_r12: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> (rd_valid && rd_data == $past(stat_q)));
endmodule

// File: rtl/txn_fail_ctrl.sv
module txn_fail_ctrl
  import txn_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int KW = KIND_W,
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_pair_ok,
  input  logic          cfg_flat_nest,
  input  logic          begin_valid,
  input  logic [ADDR_W-1:0] begin_pc,
  input  logic [ADDR_W-1:0] begin_off,
  input  logic          commit_valid,
  input  logic          insn_valid,
  input  logic [KW-1:0] insn_kind,
  input  logic          ev_conflict,
  input  logic          ev_exception,
  input  logic          ev_interrupt,
  input  logic          ev_rd_evict,
  input  logic          ev_tlb_ld,
  input  logic          ev_tlb_st,
  input  logic          ev_st_ovf,
  input  logic          stat_rd_req,
  output logic          txn_active,
  output logic          redirect_valid,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic [ADDR_W-1:0] redirect_npc,
  output logic          restore_req,
  output logic          commit_done,
  output logic          stat_rd_valid,
  output logic [SW-1:0] stat_rd_data
);
  logic          active_q, saw_save_q, fail, start;
  logic [SW-1:0] cause;

  assign fail       = |cause;
  assign start      = begin_valid && !active_q;
  assign txn_active = active_q;

  txn_cause_decode #(.KW(KW), .SW(SW)) u_dec (
    .active(active_q), .cfg_pair_ok(cfg_pair_ok), .cfg_flat_nest(cfg_flat_nest),
    .begin_valid(begin_valid), .insn_valid(insn_valid), .insn_kind(insn_kind),
    .saw_save(saw_save_q), .ev_conflict(ev_conflict), .ev_exception(ev_exception),
    .ev_interrupt(ev_interrupt), .ev_rd_evict(ev_rd_evict), .ev_tlb_ld(ev_tlb_ld),
    .ev_tlb_st(ev_tlb_st), .ev_st_ovf(ev_st_ovf), .cause(cause)
  );

  txn_seq #(.AW(ADDR_W), .KW(KW)) u_seq (
    .clk(clk), .rst(rst), .begin_valid(begin_valid), .begin_pc(begin_pc),
    .begin_off(begin_off), .commit_valid(commit_valid), .insn_valid(insn_valid),
    .insn_kind(insn_kind), .fail(fail), .active_q(active_q), .saw_save_q(saw_save_q),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .redirect_npc(redirect_npc), .restore_req(restore_req), .commit_done(commit_done)
  );

  txn_status_reg #(.SW(SW)) u_stat (
    .clk(clk), .rst(rst), .start(start), .cause(cause), .rd_req(stat_rd_req),
    .rd_valid(stat_rd_valid), .rd_data(stat_rd_data)
  );
endmodule

// File: tb/txn_fail_ctrl_tb_top.sv
`timescale 1ns/1ps
module txn_fail_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_pair_ok = 0, cfg_flat_nest = 0, begin_valid = 0, commit_valid = 0;
  logic [31:0] begin_pc = '0, begin_off = '0;
  logic insn_valid = 0;
  logic [3:0] insn_kind = '0;
  logic ev_conflict = 0, ev_exception = 0, ev_interrupt = 0, ev_rd_evict = 0;
  logic ev_tlb_ld = 0, ev_tlb_st = 0, ev_st_ovf = 0, stat_rd_req = 0;
  logic txn_active, redirect_valid, restore_req, commit_done, stat_rd_valid;
  logic [31:0] redirect_pc, redirect_npc;
  logic [8:0] stat_rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  txn_fail_ctrl dut_i (.*);

  // vector: {kind[3:0], ev[6:0] = conflict,exc,intr,rdev,tlbld,tlbst,sovf, commit, exp_fail, exp_stat[8:0]}
  localparam int NV = 21;
  localparam logic [21:0] VEC [0:NV-1] = '{
    {4'd0,  7'b0000000, 1'b1, 1'b0, 9'h000},   // R3 commit
    {4'd0,  7'b1000000, 1'b0, 1'b1, 9'h002},   // R5 conflict
    {4'd1,  7'b0000000, 1'b0, 1'b1, 9'h004},   // R5 trap
    {4'd0,  7'b0100000, 1'b0, 1'b1, 9'h010},   // R5 exception
    {4'd0,  7'b0010000, 1'b0, 1'b1, 9'h020},   // R5 interrupt
    {4'd0,  7'b0000001, 1'b0, 1'b1, 9'h040},   // R5 overflow
    {4'd0,  7'b0001000, 1'b0, 1'b1, 9'h080},   // R5 eviction
    {4'd0,  7'b0000100, 1'b0, 1'b1, 9'h080},   // R5 load miss
    {4'd0,  7'b0000010, 1'b0, 1'b1, 9'h100},   // R5 store miss
    {4'd4,  7'b0000000, 1'b0, 1'b1, 9'h008},   // R7
    {4'd5,  7'b0000000, 1'b0, 1'b1, 9'h008},
    {4'd6,  7'b0000000, 1'b0, 1'b1, 9'h008},
    {4'd7,  7'b0000000, 1'b0, 1'b1, 9'h008},
    {4'd8,  7'b0000000, 1'b0, 1'b1, 9'h008},
    {4'd9,  7'b0000000, 1'b0, 1'b1, 9'h008},
    {4'd10, 7'b0000000, 1'b0, 1'b1, 9'h008},
    {4'd0,  7'b1100010, 1'b0, 1'b1, 9'h112},   // R6 combined
    {4'd0,  7'b1000000, 1'b1, 1'b1, 9'h002},   // R11 fail beats commit
    {4'd2,  7'b0000000, 1'b0, 1'b0, 9'h000},   // R8 lone save
    {4'd3,  7'b0000000, 1'b0, 1'b0, 9'h000},   // R8 lone restore
    {4'd11, 7'b0000000, 1'b0, 1'b0, 9'h000}    // code outside unsupported set
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_in();
    begin_valid = 0; commit_valid = 0; insn_valid = 0; insn_kind = '0;
    {ev_conflict, ev_exception, ev_interrupt, ev_rd_evict, ev_tlb_ld, ev_tlb_st, ev_st_ovf} = '0;
  endtask

  task automatic do_begin(input logic [31:0] pc, input logic [31:0] off);
    begin_valid = 1; begin_pc = pc; begin_off = off;
    step(); clear_in();
  endtask

  task automatic read_stat(input string req, input logic [8:0] exp);
    stat_rd_req = 1; step(); stat_rd_req = 0;
    chk(req, {31'b0, stat_rd_valid}, 32'd1);
    chk(req, {23'b0, stat_rd_data}, {23'b0, exp});
  endtask

  task automatic insn(input logic [3:0] k);
    insn_valid = 1; insn_kind = k; step(); clear_in();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 active", {31'b0, txn_active}, 0);
    chk("R1 redirect", {31'b0, redirect_valid}, 0);
    read_stat("R1 status", 9'h000);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [3:0] k;
      logic [6:0] ev;
      logic cm, ef;
      logic [8:0] es;
      logic [31:0] pc, tgt;
      {k, ev, cm, ef, es} = VEC[i];
      pc = 32'h1000 + 32'(i) * 32'h100;
      tgt = pc + 32'h80;
      do_begin(pc, 32'h80);
      chk("R2 begin", {31'b0, txn_active}, 1);
      insn_valid = (k != 0); insn_kind = k; commit_valid = cm;
      {ev_conflict, ev_exception, ev_interrupt, ev_rd_evict, ev_tlb_ld, ev_tlb_st, ev_st_ovf} = ev;
      step(); clear_in();
      chk("R4 redirect", {31'b0, redirect_valid}, {31'b0, ef});
      chk("R4 restore", {31'b0, restore_req}, {31'b0, ef});
      if (ef) begin
        chk("R4 pc", redirect_pc, tgt);
        chk("R4 npc", redirect_npc, tgt + 32'd4);
        chk("R11 no commit", {31'b0, commit_done}, 0);
      end else begin
        chk("R3 commit", {31'b0, commit_done}, {31'b0, cm});
      end
      chk("R4 active", {31'b0, txn_active}, {31'b0, !ef && !cm});
      read_stat("R5 status", es);
      if (txn_active) begin
        commit_valid = 1; step(); clear_in();
      end
    end

    // R6 sticky then cleared by begin
    do_begin(32'h2000, 32'h10);
    ev_exception = 1; step(); clear_in();
    read_stat("R6 sticky a", 9'h010);
    read_stat("R6 sticky b", 9'h010);
    do_begin(32'h2100, 32'h10);
    read_stat("R2 cleared", 9'h000);
    commit_valid = 1; step(); clear_in();

    // R10 idle inputs ignored, R3 idle commit
    commit_valid = 1; insn_valid = 1; insn_kind = 4'd4;
    {ev_conflict, ev_exception, ev_interrupt, ev_rd_evict, ev_tlb_ld, ev_tlb_st, ev_st_ovf} = '1;
    step(); clear_in();
    chk("R10 redirect", {31'b0, redirect_valid}, 0);
    chk("R3 idle commit", {31'b0, commit_done}, 0);
    chk("R10 active", {31'b0, txn_active}, 0);
    read_stat("R10 status", 9'h000);

    // R8 save then restore
    do_begin(32'h3000, 32'h20);
    insn(4'd2);
    chk("R8 save ok", {31'b0, txn_active}, 1);
    insn(4'd3);
    chk("R8 pair fails", {31'b0, redirect_valid}, 1);
    chk("R8 pair pc", redirect_pc, 32'h3020);
    read_stat("R8 status", 9'h008);
    // R8 restore then save does not fail
    do_begin(32'h3100, 32'h20);
    insn(4'd3); insn(4'd2);
    chk("R8 restore-save", {31'b0, txn_active}, 1);
    commit_valid = 1; step(); clear_in();
    // R8 relaxed
    cfg_pair_ok = 1;
    do_begin(32'h3200, 32'h20);
    insn(4'd2); insn(4'd3);
    chk("R8 relaxed", {31'b0, txn_active}, 1);
    commit_valid = 1; step(); clear_in();
    chk("R8 relaxed commit", {31'b0, commit_done}, 1);
    cfg_pair_ok = 0;

    // R9 nested begin
    do_begin(32'h4000, 32'h40);
    do_begin(32'h5000, 32'h40);
    chk("R9 nest fails", {31'b0, redirect_valid}, 1);
    chk("R9 nest pc", redirect_pc, 32'h4040);
    read_stat("R9 status", 9'h008);
    cfg_flat_nest = 1;
    do_begin(32'h4000, 32'h40);
    do_begin(32'h5000, 32'h40);
    chk("R9 flat active", {31'b0, txn_active}, 1);
    chk("R9 flat no redirect", {31'b0, redirect_valid}, 0);
    ev_conflict = 1; step(); clear_in();
    chk("R9 flat target", redirect_pc, 32'h4040);
    chk("R9 flat npc", redirect_npc, 32'h4044);
    read_stat("R12 read", 9'h002);
    cfg_flat_nest = 0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule